// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a compact single-cycle processor for a small load/store instruction set. Each clock edge retires one instruction. The instruction word arrives combinationally on the fetch port for the current program counter. The core decodes it, reads two operands from a 32-entry register file and computes a result, a memory address or a branch decision. It writes back and moves the program counter, all in the same cycle. Register 31 is a constant zero.

Instruction and data memories are external and are read combinationally. A store presents address, data and write enable during the cycle of the store instruction, and memory captures it on the next rising edge. The core is intended as the control engine of a small subsystem that holds its program in a local ROM or RAM.

Top module: `risc_core`

## Requirements
- R1: While rst_ni is low, the fetch address is 0 and no data write is requested. The first instruction after reset is fetched from address 0. The fetch address always equals the current program counter.
- R2: Every instruction that is not a taken branch advances the program counter by 4.
- R3: Opcodes 100000 (add), 100001 (subtract) and 100010 (multiply, low 32 bits) write to rc (bits 25:21) the result of ra (bits 20:16) combined with rb (bits 15:11).
- R4: Opcodes 11xxxx are the literal forms of the 10xxxx register operations. Their second operand is bits 15:0, sign-extended, so 0xFFFD acts as -3.
- R5: Funct codes 0100 (equal), 0101 (signed less-than) and 0110 (signed less-or-equal), in bits 29:26, write 1 when the comparison is true and 0 when it is false.
- R6: Funct codes 1000 (AND), 1001 (OR) and 1010 (XOR) apply the bitwise operation.
- R7: Funct codes 1100 (shift left), 1101 (logical shift right) and 1110 (arithmetic shift right) shift ra by the low 5 bits of the second operand.
- R8: Register 31 reads as 0. Writes to register 31 are discarded.
- R9: Load (011000) writes to rc the memory word at ra + sext(literal). Store (011001) writes rc to that address. The low two address bits driven on the data port are always 0. The write enable is high only for a store.
- R10: Branch-if-zero (011100) and branch-if-nonzero (011101) write PC+4 to rc. When the condition on ra holds, they set PC to PC+4+4*sext(literal). Otherwise PC becomes PC+4.
- R11: Funct codes 0011, 0111, 1011 and 1111, and every other opcode not listed above, change no register and no memory. They only advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction fetch byte address |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address, word aligned |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store request, captured on the next rising edge |
| dmem_rdata_i | input | 32 | Load data for dmem_addr_o |

## Verification
The embedded assertions check several properties on every cycle:
- the PC step of 4 for any instruction that is not a taken branch;
- the link value of PC+4 carried by every branch;
- zero on operand reads of register 31;
- a single-bit result from every compare;
- no data write except on the store opcode;
- no side effects from unassigned codes.

Arithmetic results, sign extension of literals, shift-amount truncation, load data paths, branch targets and loop behaviour can only be shown by the bench's program. That program sends every result out through a store, and a scoreboard matches each store against an independently computed address and value. An unexpected store, such as one from an instruction that a taken branch should have skipped, is flagged as a failure.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int LIT_W  = 16;
  localparam int SH_W   = $clog2(XLEN);

  localparam logic [5:0] OPC_LD  = 6'b011000;
  localparam logic [5:0] OPC_ST  = 6'b011001;
  localparam logic [5:0] OPC_BEQ = 6'b011100;
  localparam logic [5:0] OPC_BNE = 6'b011101;

  localparam logic [3:0] FN_ADD   = 4'd0;
  localparam logic [3:0] FN_SUB   = 4'd1;
  localparam logic [3:0] FN_MUL   = 4'd2;
  localparam logic [3:0] FN_CMPEQ = 4'd4;
  localparam logic [3:0] FN_CMPLT = 4'd5;
  localparam logic [3:0] FN_CMPLE = 4'd6;
  localparam logic [3:0] FN_AND   = 4'd8;
  localparam logic [3:0] FN_OR    = 4'd9;
  localparam logic [3:0] FN_XOR   = 4'd10;
  localparam logic [3:0] FN_SHL   = 4'd12;
  localparam logic [3:0] FN_SHR   = 4'd13;
  localparam logic [3:0] FN_SAR   = 4'd14;

  typedef struct packed {
    logic [3:0] fn;
    logic       use_lit;
    logic       rf_we;
    logic       mem_we;
    logic       is_ld;
    logic       is_br;
    logic       br_if_zero;
  } ctrl_t;
endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import core_pkg::*;
(
  input  logic [5:0] opc_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.fn = FN_ADD;
    if (opc_i[5]) begin
      ctrl_o.fn      = opc_i[3:0];
      ctrl_o.use_lit = opc_i[4];
      ctrl_o.rf_we   = (opc_i[1:0] != 2'b11); // holes in the funct map are no-ops
    end else begin
      unique case (opc_i)
        OPC_LD:  begin ctrl_o.use_lit = 1'b1; ctrl_o.rf_we = 1'b1; ctrl_o.is_ld = 1'b1; end
        OPC_ST:  begin ctrl_o.use_lit = 1'b1; ctrl_o.mem_we = 1'b1; end
        OPC_BEQ: begin ctrl_o.is_br = 1'b1; ctrl_o.rf_we = 1'b1; ctrl_o.br_if_zero = 1'b1; end
        OPC_BNE: begin ctrl_o.is_br = 1'b1; ctrl_o.rf_we = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fn_i,
  output logic [W-1:0] y_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] shamt;
  logic          lt;
  assign shamt = b_i[SW-1:0];
  assign lt    = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (fn_i)
      FN_ADD:   y_o = a_i + b_i;
      FN_SUB:   y_o = a_i - b_i;
      FN_MUL:   y_o = a_i * b_i;
      FN_CMPEQ: y_o = {{(W-1){1'b0}}, a_i == b_i};
      FN_CMPLT: y_o = {{(W-1){1'b0}}, lt};
      FN_CMPLE: y_o = {{(W-1){1'b0}}, lt | (a_i == b_i)};
      FN_AND:   y_o = a_i & b_i;
      FN_OR:    y_o = a_i | b_i;
      FN_XOR:   y_o = a_i ^ b_i;
      FN_SHL:   y_o = a_i << shamt;
      FN_SHR:   y_o = a_i >> shamt;
      FN_SAR:   y_o = $signed(a_i) >>> shamt;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [$clog2(N)-1:0] raddr_a_i,
  input  logic [$clog2(N)-1:0] raddr_b_i,
  output logic [W-1:0]         rdata_a_o,
  output logic [W-1:0]         rdata_b_o,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] waddr_i,
  input  logic [W-1:0]         wdata_i
);
  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] ZERO_IDX = AW'(N - 1);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_i && waddr_i != ZERO_IDX) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == ZERO_IDX) ? '0 : regs[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == ZERO_IDX) ? '0 : regs[raddr_b_i];
endmodule

// File: rtl/risc_core.sv
module risc_core
  import core_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_data_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic        dmem_we_o,
  input  logic [31:0] dmem_rdata_i
);
  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
  logic [5:0]        opc;
  logic [RIDX_W-1:0] rc, ra, rb, rsel_b;
  logic [XLEN-1:0]   lit_sx, ra_data, rb_data, op_b, alu_y, rf_wdata, mem_addr;
  logic              take_br;
  ctrl_t             ctrl;

  assign opc    = imem_data_i[31:26];
  assign rc     = imem_data_i[25:21];
  assign ra     = imem_data_i[20:16];
  assign rb     = imem_data_i[15:11];
  assign lit_sx = {{(XLEN-LIT_W){imem_data_i[LIT_W-1]}}, imem_data_i[LIT_W-1:0]};

  core_decoder u_dec (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  // store data comes from rc through the second read port
  assign rsel_b = ctrl.mem_we ? rc : rb;

  core_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ra),
    .raddr_b_i (rsel_b),
    .rdata_a_o (ra_data),
    .rdata_b_o (rb_data),
    .we_i      (ctrl.rf_we),
    .waddr_i   (rc),
    .wdata_i   (rf_wdata)
  );

  assign op_b = ctrl.use_lit ? lit_sx : rb_data;

  core_alu #(.W(XLEN)) u_alu (
    .a_i  (ra_data),
    .b_i  (op_b),
    .fn_i (ctrl.fn),
    .y_o  (alu_y)
  );

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {lit_sx[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.is_br && ((ra_data == '0) == ctrl.br_if_zero);
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_comb begin
    if (ctrl.is_ld)      rf_wdata = dmem_rdata_i;
    else if (ctrl.is_br) rf_wdata = pc_plus4;
    else                 rf_wdata = alu_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign mem_addr     = alu_y;
  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = {mem_addr[XLEN-1:2], 2'b00};
  assign dmem_wdata_o = rb_data;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_br |=> pc_q == $past(pc_q) + 32'd4); // R2
  AST_LINK_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OPC_BEQ || opc == OPC_BNE) |-> (ctrl.rf_we && rf_wdata == pc_q + 32'd4)); // R10
  AST_ZERO_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra == 5'd31) |-> (ra_data == '0)); // R8
  AST_CMP_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc[5] && (opc[3:0] == FN_CMPEQ || opc[3:0] == FN_CMPLT || opc[3:0] == FN_CMPLE))
      |-> (alu_y[31:1] == '0)); // R5
  AST_WE_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (imem_data_i[31:26] == OPC_ST)); // R9
  AST_NOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opc[5] && opc[1:0] == 2'b11) ||
     (!opc[5] && opc != OPC_LD && opc != OPC_ST && opc != OPC_BEQ && opc != OPC_BNE))
      |-> (!ctrl.rf_we && !dmem_we_o && !take_br)); // R11
endmodule

// File: tb/sim_risc_core.sv
module sim_risc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #10 clk = ~clk;

  risc_core u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_rdata_i (dmem_rdata)
  );

  logic [31:0] imem [128];
  logic [31:0] dmem [256];
  assign imem_data  = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  typedef struct { logic [31:0] addr; logic [31:0] data; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int pidx = 0;
  logic [31:0] sa = 32'h100;

  function automatic logic [31:0] enc_r(logic [5:0] op, int c, int a, int b);
    return {op, 5'(c), 5'(a), 5'(b), 11'd0};
  endfunction
  function automatic logic [31:0] enc_l(logic [5:0] op, int c, int a, logic [15:0] lit);
    return {op, 5'(c), 5'(a), lit};
  endfunction

  task automatic emit(logic [31:0] w);
    imem[pidx] = w;
    pidx++;
  endtask
  // driver: store a register to the next slot and queue the expected write
  task automatic st_chk(int r, logic [31:0] v, string req);
    exp_t e;
    emit(enc_l(6'b011001, r, 31, sa[15:0]));
    e.addr = sa; e.data = v; e.req = req;
    exp_q.push_back(e);
    sa += 32'd4;
  endtask
  task automatic push_raw(logic [31:0] a, logic [31:0] v, string req);
    exp_t e;
    e.addr = a; e.data = v; e.req = req;
    exp_q.push_back(e);
  endtask
  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected store", dmem_addr, 32'hxxxxxxxx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(dmem_addr == e.addr, {e.req, " addr"}, dmem_addr, e.addr);
        check(dmem_wdata == e.data, {e.req, " data"}, dmem_wdata, e.data);
      end
    end
  end

  initial begin
    int halt_pc, b, lp, cyc;
    for (int k = 0; k < 128; k++) imem[k] = 32'h0;
    for (int k = 0; k < 256; k++) dmem[k] = 32'h0;

    emit(enc_l(6'b110000, 1, 31, 16'd5));        // r1 = 5
    emit(enc_l(6'b110000, 2, 31, 16'hFFFD));     // r2 = -3, R4
    emit(32'h80611000);                          // r3 = r1 + r2
    st_chk(3, 32'd2, "R3 add");
    emit(enc_r(6'b100001, 4, 1, 2)); st_chk(4, 32'd8, "R3 sub");
    emit(enc_r(6'b100010, 5, 1, 2)); st_chk(5, -32'sd15, "R3 mul");
    emit(enc_l(6'b110001, 6, 1, 16'hFFFF)); st_chk(6, 32'd6, "R4 subc");
    emit(enc_l(6'b110010, 6, 2, 16'hFFFE)); st_chk(6, 32'd6, "R4 mulc");
    emit(enc_r(6'b100101, 7, 2, 1)); st_chk(7, 32'd1, "R5 lt true");
    emit(enc_r(6'b100101, 8, 1, 2)); st_chk(8, 32'd0, "R5 lt signed false");
    emit(enc_r(6'b100110, 9, 1, 1)); st_chk(9, 32'd1, "R5 le equal");
    emit(enc_r(6'b100100, 8, 1, 2)); st_chk(8, 32'd0, "R5 eq false");
    emit(enc_l(6'b110100, 10, 2, 16'hFFFD)); st_chk(10, 32'd1, "R5 eqc true");
    emit(enc_l(6'b110101, 10, 2, 16'hFFFC)); st_chk(10, 32'd0, "R5 ltc false");
    emit(enc_l(6'b111000, 6, 1, 16'd12)); st_chk(6, 32'd4, "R6 andc");
    emit(enc_l(6'b111001, 6, 1, 16'd12)); st_chk(6, 32'd13, "R6 orc");
    emit(enc_l(6'b111010, 6, 1, 16'd12)); st_chk(6, 32'd9, "R6 xorc");
    emit(enc_r(6'b101000, 6, 1, 2)); st_chk(6, 32'd5, "R6 and");
    emit(enc_l(6'b111100, 6, 2, 16'd4)); st_chk(6, 32'hFFFFFFD0, "R7 shlc");
    emit(enc_l(6'b111101, 6, 2, 16'd28)); st_chk(6, 32'h0000000F, "R7 shrc");
    emit(enc_l(6'b111110, 6, 2, 16'd1)); st_chk(6, 32'hFFFFFFFE, "R7 sarc");
    emit(enc_l(6'b110000, 9, 31, 16'd33));       // r9 = 33, low 5 bits = 1
    emit(enc_r(6'b101100, 10, 1, 9)); st_chk(10, 32'd10, "R7 shl amount mod 32");
    emit(enc_l(6'b110000, 31, 31, 16'd7)); st_chk(31, 32'd0, "R8 write discarded");
    emit(enc_r(6'b100000, 12, 31, 1)); st_chk(12, 32'd5, "R8 read zero");
    emit(enc_l(6'b011000, 11, 31, 16'h0101)); st_chk(11, 32'd2, "R9 load low bits ignored");
    emit(enc_l(6'b110000, 13, 31, 16'h0300));
    emit(enc_l(6'b011001, 1, 13, 16'hFFFF)); push_raw(32'h000002FC, 32'd5, "R9 store base+negative");
    emit(32'h00000000);
    emit(enc_r(6'b100011, 1, 2, 2));
    emit(enc_l(6'b111111, 1, 2, 16'd1));
    emit(enc_l(6'b000101, 1, 2, 16'd1));
    st_chk(1, 32'd5, "R11 unassigned no effect");
    b = pidx;
    emit(enc_l(6'b011100, 12, 31, 16'd1));       // taken, skips next
    emit(enc_l(6'b011001, 2, 31, 16'h03F0));     // must not execute
    st_chk(12, 32'(4 * (b + 1)), "R10 beq link");
    b = pidx;
    emit(enc_l(6'b011101, 13, 31, 16'd1));       // not taken
    st_chk(13, 32'(4 * (b + 1)), "R10 bne fallthrough link");
    emit(enc_l(6'b110000, 14, 31, 16'd3));
    emit(enc_l(6'b110000, 15, 31, 16'd0));
    lp = pidx;
    emit(enc_l(6'b110001, 14, 14, 16'd1));
    emit(enc_l(6'b110000, 15, 15, 16'd1));
    b = pidx;
    emit(enc_l(6'b011101, 31, 14, 16'(lp - (b + 1))));
    st_chk(15, 32'd3, "R10 backward loop count");
    halt_pc = 4 * pidx;
    emit(enc_l(6'b011100, 31, 31, 16'hFFFF));   // self loop

    repeat (2) @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
    check(dmem_we == 1'b0, "R1 reset no write", {31'd0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(imem_addr == 32'h4, "R2 first step", imem_addr, 32'h4);

    cyc = 0;
    while (exp_q.size() != 0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 2000) check(1'b0, "watchdog", 32'(exp_q.size()), 32'h0);
    repeat (6) @(negedge clk);
    check(imem_addr == 32'(halt_pc), "R10 self branch holds pc", imem_addr, 32'(halt_pc));
    check(exp_q.size() == 0, "R2 all stores seen", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule